// File: doc/BRIEF.md
# Received-Packet Header and Data CRC Checker

This block watches a received byte stream and runs an 8-bit CRC over every packet. It treats each packet as a remote memory access frame, whatever the bytes contain. The instruction byte, which is the third byte of the packet, tells the block how long the header is. When the last header byte, which is the header CRC byte, has been absorbed, the block tests the running CRC register. A nonzero value marks a header CRC error.

The register is not cleared at that point. It keeps accumulating over the data field and its CRC byte. When the end-of-packet marker arrives, a nonzero remainder marks a data CRC error. The marker itself is not part of the CRC. Because the CRC runs once across the whole packet, a bad header also makes the data flag read as failed, so the data flag only carries information when the header flag is clear.

Both flags are reported one cycle after the end marker, together with a one-cycle completion pulse. The flags then hold until the next packet starts. The block is fed by a link receiver with a valid, a start marker on the first data byte, and one end marker beat. That end beat stands for both normal and error endings and carries no data.

Top module: `rmap_crc_check`

## Requirements
- R1: After reset, `pkt_done`, `hdr_crc_err` and `data_crc_err` are all 0.
- R2: The CRC uses polynomial x^8+x^2+x+1 with initial value 0x00 and takes each byte least-significant bit first. A field followed by its correct CRC byte leaves a zero remainder, so a packet with correct header and data CRCs reports both flags 0.
- R3: The instruction byte is byte index 2, counting from 0. When its bit 6 is 1 (command), the header length including the CRC byte is 16 + 4 × (bits 1:0) bytes.
- R4: When instruction bit 6 is 0 (reply), the header length is 8 bytes if bit 5 is 1 (write reply) and 12 bytes if bit 5 is 0 (read reply).
- R5: `hdr_crc_err` is 1 exactly when the CRC remainder after the last header byte is nonzero, provided the packet reached the end of its header.
- R6: The CRC continues from the header into the data field without reinitialisation. `data_crc_err` is 1 when the remainder over all data bytes before the end marker is nonzero. The end marker beat's data is not included.
- R7: A packet with a corrupted header and a correct data field with its own CRC reports both `hdr_crc_err` and `data_crc_err` as 1.
- R8: A packet that ends before its header is complete, including an empty packet, reports `hdr_crc_err` = 1 and `data_crc_err` = 0.
- R9: `pkt_done` is 1 for exactly the one cycle after an end marker beat. The flags are updated in that cycle and hold their values until the next start or end beat.
- R10: A data beat with `in_sop` = 1 clears both flags in the next cycle and restarts the CRC and byte count, even in the middle of a packet. An end marker beat also leaves the block ready for a new packet.
- R11: Cycles with `in_valid` = 0 have no effect, whatever `in_data`, `in_sop` and `in_end` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat valid |
| in_data | input | 8 | Received byte, used on data beats only |
| in_sop | input | 1 | First byte of a packet (data beats only) |
| in_end | input | 1 | End marker beat (normal or error end), carries no data |
| pkt_done | output | 1 | One-cycle pulse after an end marker |
| hdr_crc_err | output | 1 | Header CRC failed or header incomplete |
| data_crc_err | output | 1 | Remainder over the whole packet nonzero |

## Verification
The sweep covers every command reply-address-length code, both with the write bit set and clear, and both reply kinds. Each is sent with and without a data field, and with the damage placed in a header byte, in the header CRC byte or in a data byte. A design that fixed the header length or read the wrong instruction bits would test the remainder at the wrong byte and flag good packets. One that cleared the CRC after the header would miss the required data failure on header-damaged packets. Truncations at zero bytes, before the instruction byte and one byte short of the header catch a block that ends packets with a stale header result. Idle cycles carrying start and end values, and a restart in the middle of a packet, catch ungated beats and a start marker that fails to reset the state.

// File: rtl/rmap_crc_pkg.sv
package rmap_crc_pkg;
  localparam int          CRC_W       = 8;
  localparam logic [7:0]  POLY_REFL   = 8'hE0;  // x^8+x^2+x+1, bit-reversed
  localparam int          LEN_W       = 5;
  localparam int          INSTR_IDX   = 2;
  localparam int          CMD_BASE    = 16;
  localparam int          RPL_WR_LEN  = 8;
  localparam int          RPL_RD_LEN  = 12;

  // one byte through the CRC register, least-significant bit first
  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c,
                                                 input logic [7:0] b);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

  // header length in bytes, header CRC byte included
  function automatic logic [LEN_W-1:0] hdr_len_of(input logic [7:0] instr);
    if (instr[6])      return LEN_W'(CMD_BASE + 4 * int'(instr[1:0]));
    else if (instr[5]) return LEN_W'(RPL_WR_LEN);
    else               return LEN_W'(RPL_RD_LEN);
  endfunction
endpackage

// File: rtl/rmap_crc_acc.sv
module rmap_crc_acc
  import rmap_crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sop,
  input  logic             clr,
  input  logic [7:0]       data,
  output logic [CRC_W-1:0] crc_q,
  output logic [CRC_W-1:0] crc_nxt
);
  assign crc_nxt = crc8_step(sop ? '0 : crc_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= '0;
    else if (beat)     crc_q <= crc_nxt;
  end
endmodule

// File: rtl/rmap_hdr_track.sv
module rmap_hdr_track
  import rmap_crc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       sop,
  input  logic       clr,
  input  logic [7:0] data,
  output logic       hdr_hit,
  output logic       hdr_seen
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, base_cnt, cnt_nxt;
  logic [LEN_W-1:0] len_q, len_use;
  logic             seen_q, seen_base;
  logic             at_instr;

  assign base_cnt  = sop ? '0 : cnt_q;
  assign seen_base = sop ? 1'b0 : seen_q;
  assign at_instr  = (base_cnt == CNT_W'(INSTR_IDX));
  assign len_use   = at_instr ? hdr_len_of(data) : len_q;
  assign cnt_nxt   = (base_cnt == CNT_MAX) ? CNT_MAX : base_cnt + 1'b1;
  assign hdr_hit   = beat && !seen_base && (base_cnt >= CNT_W'(INSTR_IDX)) &&
                     (cnt_nxt == CNT_W'(len_use));
  assign hdr_seen  = seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q  <= '0;
      len_q  <= '0;
      seen_q <= 1'b0;
    end else if (beat) begin
      cnt_q  <= cnt_nxt;
      if (at_instr) len_q <= len_use;
      seen_q <= seen_base | hdr_hit;
    end
  end
endmodule

// File: rtl/rmap_crc_check.sv
module rmap_crc_check
  import rmap_crc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_end,
  output logic       pkt_done,
  output logic       hdr_crc_err,
  output logic       data_crc_err
);
  logic             data_beat, sop_beat, end_beat;
  logic             hdr_hit, hdr_seen;
  logic             hdr_res_bad;
  logic [CRC_W-1:0] crc_q, crc_nxt;

  assign data_beat = in_valid && !in_end;
  assign sop_beat  = data_beat && in_sop;
  assign end_beat  = in_valid && in_end;

  rmap_crc_acc u_acc (
    .clk(clk), .rst_n(rst_n), .beat(data_beat), .sop(sop_beat), .clr(end_beat),
    .data(in_data), .crc_q(crc_q), .crc_nxt(crc_nxt)
  );

  rmap_hdr_track #(.CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .beat(data_beat), .sop(sop_beat), .clr(end_beat),
    .data(in_data), .hdr_hit(hdr_hit), .hdr_seen(hdr_seen)
  );

  // remainder captured at the header boundary
  always_ff @(posedge clk) begin
    if (!rst_n || end_beat) hdr_res_bad <= 1'b0;
    else if (hdr_hit)       hdr_res_bad <= (crc_nxt != '0);
    else if (sop_beat)      hdr_res_bad <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_done     <= 1'b0;
      hdr_crc_err  <= 1'b0;
      data_crc_err <= 1'b0;
    end else if (end_beat) begin
      pkt_done     <= 1'b1;
      hdr_crc_err  <= hdr_seen ? hdr_res_bad : 1'b1;
      data_crc_err <= hdr_seen && (crc_q != '0);
    end else begin
      pkt_done <= 1'b0;
      if (sop_beat) begin
        hdr_crc_err  <= 1'b0;
        data_crc_err <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rmap_crc_check_chk.sv
module rmap_crc_check_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_sop,
  input logic in_end,
  input logic pkt_done,
  input logic hdr_crc_err,
  input logic data_crc_err,
  input logic hdr_seen
);
  // R9
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_end) |=> pkt_done);

  // R9
  done_only_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(in_valid && in_end));

  // R8
  short_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_end && !hdr_seen) |=> (hdr_crc_err && !data_crc_err));

  // R10
  sop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_end && in_sop) |=> (!hdr_crc_err && !data_crc_err && !pkt_done));

  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && (in_sop || in_end)) |=> ($stable(hdr_crc_err) && $stable(data_crc_err)));

  // R7
  hdr_fail_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && hdr_crc_err && !data_crc_err) |-> !$past(hdr_seen));
endmodule

bind rmap_crc_check rmap_crc_check_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_end(in_end),
  .pkt_done(pkt_done), .hdr_crc_err(hdr_crc_err), .data_crc_err(data_crc_err),
  .hdr_seen(hdr_seen)
);

// File: tb/rmap_crc_check_test.sv
module rmap_crc_check_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_sop = 1'b0;
  logic       in_end = 1'b0;
  logic       pkt_done, hdr_crc_err, data_crc_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] pkt [0:63];

  always #4 clk = ~clk;

  rmap_crc_check uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sop(in_sop), .in_end(in_end), .pkt_done(pkt_done),
    .hdr_crc_err(hdr_crc_err), .data_crc_err(data_crc_err)
  );

  // bench CRC: xor the byte in, then eight reflected division steps
  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    repeat (8) r = r[0] ? ((r >> 1) ^ 8'hE0) : (r >> 1);
    return r;
  endfunction

  function automatic logic [7:0] crc_range(input int lo, input int hi);
    logic [7:0] r;
    r = 8'h00;
    for (int i = lo; i < hi; i++) r = bcrc(r, pkt[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got done/hdr/data=%b expected %b", req, got, exp);
    end
  endtask

  // drive n bytes of pkt; gap idle cycles with misleading values after each byte
  task automatic send_bytes(input int n, input int gap, input bit first_sop);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = pkt[i]; in_sop = first_sop && (i == 0); in_end = 1'b0;
      @(negedge clk);
      for (int g = 0; g < gap; g++) begin
        in_valid = 1'b0; in_data = 8'($urandom); in_sop = 1'b1; in_end = 1'b1;
        @(negedge clk);
      end
    end
    in_valid = 1'b0; in_sop = 1'b0; in_end = 1'b0;
  endtask

  task automatic send_end();
    in_valid = 1'b1; in_end = 1'b1; in_sop = 1'b0; in_data = 8'h5A;
    @(negedge clk);
    in_valid = 1'b0; in_end = 1'b0;
  endtask

  task automatic run_pkt(input int n, input int gap, input logic hx, input logic dx,
                         input string req);
    send_bytes(n, gap, 1'b1);
    send_end();
    check(req, {pkt_done, hdr_crc_err, data_crc_err}, {1'b1, hx, dx});
    @(negedge clk);
    check("R9 hold", {pkt_done, hdr_crc_err, data_crc_err}, {1'b0, hx, dx});
  endtask

  function automatic logic [7:0] instr_of(input int t);
    if (t < 8) return {1'b0, 1'b1, t[2], 3'b000, t[1:0]};
    else if (t == 8) return 8'h20;
    else return 8'h00;
  endfunction

  function automatic int hlen_of(input int t);
    if (t < 8) return 16 + 4 * (t % 4);
    else if (t == 8) return 8;
    else return 12;
  endfunction

  // header then optional data field, both with correct CRC bytes
  task automatic build(input int t, input int p, output int n);
    int h;
    h = hlen_of(t);
    for (int i = 0; i < 64; i++) pkt[i] = 8'((i * 37 + t * 11 + 3) ^ 8'h6C);
    pkt[2] = instr_of(t);
    pkt[h-1] = crc_range(0, h - 1);
    n = h;
    if (p > 0) begin
      pkt[h+p] = crc_range(h, h + p);
      n = h + p + 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", {pkt_done, hdr_crc_err, data_crc_err}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R11 sweep
    for (int t = 0; t < 10; t++) begin
      for (int p = 0; p <= 3; p += 3) begin
        for (int m = 0; m < 4; m++) begin
          int h;
          h = hlen_of(t);
          if (m == 3 && p == 0) continue;
          build(t, p, n);
          if (m == 1) pkt[1] = pkt[1] ^ 8'h10;
          if (m == 2) pkt[h-1] = pkt[h-1] ^ 8'h01;
          if (m == 3) pkt[h+1] = pkt[h+1] ^ 8'h80;
          case (m)
            0: run_pkt(n, (t + p) % 3, 1'b0, 1'b0, t < 8 ? "R3 R2 good command" : "R4 R2 good reply");
            1: run_pkt(n, t % 2, 1'b1, 1'b1, "R5 R7 header byte damaged");
            2: run_pkt(n, 0, 1'b1, 1'b1, "R5 R7 header CRC damaged");
            default: run_pkt(n, 2, 1'b0, 1'b1, "R6 data byte damaged");
          endcase
        end
      end
    end

    // R8 truncated headers
    for (int t = 0; t < 10; t++) begin
      build(t, 0, n);
      run_pkt(0, 0, 1'b1, 1'b0, "R8 empty packet");
      run_pkt(2, 1, 1'b1, 1'b0, "R8 cut before instruction");
      run_pkt(hlen_of(t) - 1, 0, 1'b1, 1'b0, "R8 cut one short");
    end

    // R6: data beats after the header with the end marker carrying junk
    build(9, 5, n);
    run_pkt(n, 0, 1'b0, 1'b0, "R6 end marker excluded");

    // R10 restart in mid packet
    build(3, 0, n);
    pkt[0] = 8'hEE; pkt[1] = 8'h01; pkt[2] = 8'h40; pkt[3] = 8'h99;
    send_bytes(4, 0, 1'b1);
    build(3, 4, n);
    run_pkt(n, 0, 1'b0, 1'b0, "R10 restart mid packet");

    // R10 sop clears flags of previous bad packet
    build(5, 0, n);
    pkt[0] = pkt[0] ^ 8'h04;
    run_pkt(n, 0, 1'b1, 1'b1, "R5 before clear");
    build(5, 0, n);
    send_bytes(1, 0, 1'b1);
    check("R10 flags cleared by sop", {pkt_done, hdr_crc_err, data_crc_err}, 3'b000);
    for (int i = 0; i < n - 1; i++) pkt[i] = pkt[i+1];
    send_bytes(n - 1, 0, 1'b0);
    send_end();
    check("R10 continued packet", {pkt_done, hdr_crc_err, data_crc_err}, 3'b100);

    // R11 idle cycles only: nothing changes
    repeat (4) begin
      in_valid = 1'b0; in_sop = 1'b1; in_end = 1'b1; in_data = 8'hFF;
      @(negedge clk);
    end
    in_sop = 1'b0; in_end = 1'b0;
    check("R11 idle ignored", {pkt_done, hdr_crc_err, data_crc_err}, 3'b000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule